// File: doc/BRIEF.md
# Vector Compressed Index Generator

This block reads the elements of a vector one at a time and tests each one against a condition chosen at launch. It builds a bit mask of the outcomes. It also emits a dense stream that carries only the positions of the elements that passed. That stream can feed a gather or scatter unit directly, so a data-dependent conditional becomes a vectorised indexed access instead of a branch per element.

A launch pulse captures the element count, the condition code and an index stride. The producer then presents elements on a valid-qualified port, at a rate of up to one per clock. For each passing element the block emits its element number multiplied by the stride, in ascending element order. It keeps a running count of the emitted entries. After the last element it raises a one-cycle completion pulse. The mask and the count stay unchanged until the next launch.

Top module: `vcidx_gen`

## Requirements
- R1: While reset is high and after its release, `busy`, `done` and `idx_valid` are 0, and `mask` and `idx_count` are all zeros.
- R2: A `start` pulse while `busy` is 0 captures `vlen`, `cond` and `stride`. It clears `mask` and `idx_count` and drops `idx_valid`. In the next cycle `busy` is 1 if the effective length is non-zero.
- R3: While busy, the block consumes exactly one element in each cycle that has `elem_valid` high. A cycle with `elem_valid` low consumes nothing and produces no index.
- R4: The condition codes are: 2'b00 selects elements equal to zero; 2'b01 selects non-zero elements; 2'b10 selects elements whose bit 63 is 0 (zero counts as passing); 2'b11 selects elements whose bit 63 is 1.
- R5: Passing element i sets `mask` bit (63 − i), so element 0 maps to the most significant bit. Bits for elements at or past the effective length remain 0.
- R6: In the cycle after a passing element i is consumed, `idx_valid` is 1 and `idx_data` equals (i × stride) modulo 2^24. Indices appear in ascending element order, and failing elements produce no entry.
- R7: `idx_count` equals the number of entries emitted since the last launch, and it always equals the number of set bits in `mask`.
- R8: `done` is high for exactly one cycle: the cycle after the last element is consumed. In that same cycle `busy` has returned to 0.
- R9: A launch with `vlen` equal to 0 raises `done` in the next cycle, with `mask` and `idx_count` zero and `busy` remaining 0.
- R10: A `start` pulse while `busy` is 1 is ignored. The run in progress continues with its original length, condition and stride.
- R11: A `vlen` value above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch pulse, accepted only when idle |
| vlen | input | 7 | Number of elements to scan (clamped to 64) |
| cond | input | 2 | Condition code, see R4 |
| stride | input | 24 | Multiplier applied to each emitted element number |
| elem_valid | input | 1 | Element present on `elem_data` |
| elem_data | input | 64 | Element value, two's complement |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| mask | output | 64 | Per-element result, element 0 in bit 63 |
| idx_valid | output | 1 | `idx_data` holds a new entry |
| idx_data | output | 24 | Scaled index of a passing element |
| idx_count | output | 7 | Entries emitted since the last launch |

## Verification
On every cycle the assertions check these invariants: the mask popcount matches the entry count; launch clears the outputs; `done` is a single pulse and never overlaps `busy`; a zero-length launch completes at once; and no index appears without a consumed element. Some behaviour only the scenarios can show: the exact mask bit positions, the scaled index values and their order, the meaning of each condition code, length clamping, and the fact that a second launch during a scan changes nothing. These depend on the element values the bench streams in and the model it computes.

// File: rtl/vcidx_pkg.sv
package vcidx_pkg;
  typedef enum logic [1:0] {
    CND_ZERO    = 2'b00,
    CND_NONZERO = 2'b01,
    CND_POS     = 2'b10,
    CND_NEG     = 2'b11
  } cond_e;
endpackage

// File: rtl/vcidx_cond.sv
module vcidx_cond
  import vcidx_pkg::*;
#(
  parameter int ELEM_W = 64
) (
  input  cond_e              sel,
  input  logic [ELEM_W-1:0]  value,
  output logic               hit
);
  // R4: sign tests look only at the top bit; zero counts as positive
  always_comb begin
    hit = 1'b0;
    unique case (sel)
      CND_ZERO:    hit = (value == '0);
      CND_NONZERO: hit = |value;
      CND_POS:     hit = ~value[ELEM_W-1];
      CND_NEG:     hit = value[ELEM_W-1];
    endcase
  end
endmodule

// File: rtl/vcidx_seq.sv
module vcidx_seq
  import vcidx_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int POS_W   = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] vlen,
  input  cond_e            cond_in,
  input  logic             elem_valid,
  output logic             accept,
  output logic             take,
  output logic [POS_W-1:0] pos,
  output cond_e            cond_q,
  output logic             busy,
  output logic             done
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] eff_len;
  logic             at_last;

  // R11: clamp the requested length
  assign eff_len = (vlen > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : vlen;
  // R10: a launch is only taken when idle
  assign accept  = start && !busy;
  // R3: consume only on valid cycles during a run
  assign take    = busy && elem_valid;
  assign at_last = (LEN_W'(pos) == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      pos    <= '0;
      len_q  <= '0;
      cond_q <= CND_ZERO;
    end else begin
      done <= 1'b0;
      if (accept) begin
        len_q  <= eff_len;
        cond_q <= cond_in;
        pos    <= '0;
        if (eff_len == '0) done <= 1'b1;   // R9
        else               busy <= 1'b1;   // R2
      end else if (take) begin
        pos <= pos + POS_W'(1);
        if (at_last) begin                 // R8
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vcidx_pack.sv
module vcidx_pack #(
  parameter int MAX_LEN = 64,
  parameter int IDX_W   = 24,
  parameter int CNT_W   = $clog2(MAX_LEN + 1),
  parameter int POS_W   = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [IDX_W-1:0]   stride_in,
  input  logic               take,
  input  logic               hit,
  input  logic [POS_W-1:0]   pos,
  output logic [MAX_LEN-1:0] mask,
  output logic               idx_valid,
  output logic [IDX_W-1:0]   idx_data,
  output logic [CNT_W-1:0]   idx_count
);
  logic [IDX_W-1:0]   stride_q;
  logic [IDX_W-1:0]   acc;
  logic [MAX_LEN-1:0] set_v;
  logic               pass;

  assign pass = take && hit;

  // R5: element i lands at bit MAX_LEN-1-i
  for (genvar g = 0; g < MAX_LEN; g++) begin : g_bit
    localparam int ELEM = MAX_LEN - 1 - g;
    assign set_v[g] = pass && (pos == POS_W'(ELEM));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stride_q  <= '0;
      acc       <= '0;
      mask      <= '0;
      idx_valid <= 1'b0;
      idx_data  <= '0;
      idx_count <= '0;
    end else if (clear) begin
      stride_q  <= stride_in;
      acc       <= '0;
      mask      <= '0;
      idx_valid <= 1'b0;
      idx_count <= '0;
    end else begin
      idx_valid <= pass;
      mask      <= mask | set_v;
      if (take) acc <= acc + stride_q;     // running i*stride, no multiplier
      if (pass) begin                      // R6, R7
        idx_data  <= acc;
        idx_count <= idx_count + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/vcidx_gen.sv
module vcidx_gen
  import vcidx_pkg::*;
#(
  parameter int ELEM_W  = 64,
  parameter int MAX_LEN = 64,
  parameter int IDX_W   = 24,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [LEN_W-1:0]   vlen,
  input  logic [1:0]         cond,
  input  logic [IDX_W-1:0]   stride,
  input  logic               elem_valid,
  input  logic [ELEM_W-1:0]  elem_data,
  output logic               busy,
  output logic               done,
  output logic [MAX_LEN-1:0] mask,
  output logic               idx_valid,
  output logic [IDX_W-1:0]   idx_data,
  output logic [LEN_W-1:0]   idx_count
);
  localparam int POS_W = $clog2(MAX_LEN);

  logic             accept;
  logic             take;
  logic             hit;
  logic [POS_W-1:0] pos;
  cond_e            cond_q;

  vcidx_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .vlen(vlen),
    .cond_in(cond_e'(cond)), .elem_valid(elem_valid),
    .accept(accept), .take(take), .pos(pos), .cond_q(cond_q),
    .busy(busy), .done(done)
  );

  vcidx_cond #(.ELEM_W(ELEM_W)) u_cond (
    .sel(cond_q), .value(elem_data), .hit(hit)
  );

  vcidx_pack #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .CNT_W(LEN_W), .POS_W(POS_W)) u_pack (
    .clk(clk), .rst(rst), .clear(accept), .stride_in(stride),
    .take(take), .hit(hit), .pos(pos),
    .mask(mask), .idx_valid(idx_valid), .idx_data(idx_data), .idx_count(idx_count)
  );
endmodule

// File: rtl/vcidx_chk.sv
module vcidx_chk #(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [LEN_W-1:0]   vlen,
  input logic               elem_valid,
  input logic               busy,
  input logic               done,
  input logic [MAX_LEN-1:0] mask,
  input logic               idx_valid,
  input logic [LEN_W-1:0]   idx_count
);
  p_launch_clear_r2: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> (mask == '0) && (idx_count == '0) && !idx_valid);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !idx_valid);

  p_pop_match_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(mask) == int'(idx_count));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_empty_run_r9: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (vlen == '0) |=> done && !busy);

  p_relaunch_r10: assert property (@(posedge clk) disable iff (rst)
    busy && start && !elem_valid |=> $stable(idx_count) && !idx_valid && $stable(mask));
endmodule

bind vcidx_gen vcidx_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .vlen(vlen), .elem_valid(elem_valid),
  .busy(busy), .done(done), .mask(mask), .idx_valid(idx_valid), .idx_count(idx_count)
);

// File: tb/vcidx_gen_test.sv
`timescale 1ns/1ps
module vcidx_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [6:0]  vlen = '0;
  logic [1:0]  cond = '0;
  logic [23:0] stride = '0;
  logic        elem_valid = 1'b0;
  logic [63:0] elem_data = '0;
  logic        busy, done, idx_valid;
  logic [63:0] mask;
  logic [23:0] idx_data;
  logic [6:0]  idx_count;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  vcidx_gen uut (
    .clk(clk), .rst(rst), .start(start), .vlen(vlen), .cond(cond), .stride(stride),
    .elem_valid(elem_valid), .elem_data(elem_data), .busy(busy), .done(done),
    .mask(mask), .idx_valid(idx_valid), .idx_data(idx_data), .idx_count(idx_count)
  );

  typedef struct packed {
    logic [7:0]  len;
    logic [1:0]  cnd;
    logic [23:0] strd;
    logic [1:0]  kind;
  } case_t;

  localparam case_t CASES [0:7] = '{
    '{8'd64,  2'd0, 24'd1,        2'd0},
    '{8'd64,  2'd1, 24'd1,        2'd0},
    '{8'd17,  2'd2, 24'd8,        2'd2},
    '{8'd33,  2'd3, 24'd3,        2'd2},
    '{8'd1,   2'd1, 24'd5,        2'd0},
    '{8'd100, 2'd3, 24'd1,        2'd1},
    '{8'd5,   2'd2, 24'd0,        2'd1},
    '{8'd64,  2'd1, 24'hFFFFFF,   2'd3}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] gen(input int kind, input int i);
    logic [63:0] x;
    case (kind)
      0: case (i % 4)
           0: gen = 64'd0;
           1: gen = 64'd1 << i;
           2: gen = -(64'(i) + 64'd1);
           default: gen = 64'(i) * 64'd4096 + 64'd7;
         endcase
      1: gen = (i % 5 == 0) ? 64'(i) : (64'h8000_0000_0000_0000 | 64'(i));
      2: begin
           x = (64'(i) + 64'd1) * 64'h9E37_79B9_7F4A_7C15;
           gen = x ^ (x >> 29);
         end
      default: gen = (i % 2 == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0;
    endcase
  endfunction

  function automatic bit passes(input logic [1:0] c, input logic [63:0] v);
    case (c)
      2'd0: passes = (v == 64'd0);
      2'd1: passes = (v != 64'd0);
      2'd2: passes = !v[63];
      default: passes = v[63];
    endcase
  endfunction

  task automatic run_case(input int len, input logic [1:0] c, input logic [23:0] s,
                          input int kind, input bit gaps);
    int          eff;
    logic [63:0] exp_mask;
    int          exp_cnt;
    logic [63:0] v;
    logic [23:0] exp_idx;
    bit          p;
    eff = (len > 64) ? 64 : len;         // R11
    exp_mask = '0;
    exp_cnt  = 0;
    @(negedge clk);
    start = 1'b1; vlen = 7'(len > 127 ? 127 : len); cond = c; stride = s;
    @(negedge clk);
    start = 1'b0;
    chk(busy == (eff != 0), "R2 busy after launch", 64'(busy), 64'(eff != 0));
    chk(idx_count == 0 && mask == 0, "R2 cleared", mask, 64'd0);
    if (eff == 0) begin
      chk(done == 1'b1, "R9 done", 64'(done), 64'd1);
    end
    for (int i = 0; i < eff; i++) begin
      if (gaps && (i % 7 == 3)) begin
        elem_valid = 1'b0;
        elem_data  = 64'hDEAD_0000_0000_0000;
        @(negedge clk);
        chk(!idx_valid, "R3 gap", 64'(idx_valid), 64'd0);
      end
      v = gen(kind, i);
      elem_valid = 1'b1;
      elem_data  = v;
      @(negedge clk);
      p = passes(c, v);
      exp_idx = 24'((64'(i) * 64'(s)) & 64'hFF_FFFF);
      chk(idx_valid == p, "R4 hit", 64'(idx_valid), 64'(p));
      if (p) begin
        exp_mask[63 - i] = 1'b1;
        exp_cnt++;
        chk(idx_data == exp_idx, "R6 index", 64'(idx_data), 64'(exp_idx));
      end
      if (i < eff - 1) chk(!done, "R8 early done", 64'(done), 64'd0);
    end
    elem_valid = 1'b0;
    if (eff > 0) begin
      chk(done && !busy, "R8 finish", {62'd0, done, busy}, 64'd2);
      if (len > 64) chk(eff == 64 && !busy, "R11 clamp", 64'(busy), 64'd0);
    end
    chk(mask == exp_mask, "R5 mask", mask, exp_mask);
    chk(int'(idx_count) == exp_cnt, "R7 count", 64'(idx_count), 64'(exp_cnt));
    @(negedge clk);
    chk(!done, "R8 pulse width", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !idx_valid && mask == 0 && idx_count == 0,
        "R1 reset state", mask, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !idx_valid, "R1 after release", {61'd0, busy, done, idx_valid}, 64'd0);

    for (int k = 0; k < 8; k++) begin
      run_case(int'(CASES[k].len), CASES[k].cnd, CASES[k].strd, int'(CASES[k].kind), k[0]);
    end

    // R9: zero length, issued twice back to back
    run_case(0, 2'd1, 24'd1, 0, 1'b0);
    run_case(0, 2'd0, 24'd9, 3, 1'b0);

    // R10: relaunch during a run is ignored
    @(negedge clk);
    start = 1'b1; vlen = 7'd4; cond = 2'd1; stride = 24'd2;
    @(negedge clk);
    start = 1'b0;
    elem_valid = 1'b1; elem_data = gen(0, 0);
    @(negedge clk);
    start = 1'b1; vlen = 7'd0; cond = 2'd0; stride = 24'd7;
    elem_data = gen(0, 1);
    @(negedge clk);
    start = 1'b0;
    chk(!done && busy, "R10 relaunch ignored", {62'd0, done, busy}, 64'd1);
    chk(idx_valid && idx_data == 24'd2, "R10 old stride kept", 64'(idx_data), 64'd2);
    elem_data = gen(0, 2);
    @(negedge clk);
    chk(idx_valid && idx_data == 24'd4, "R10 old condition kept", 64'(idx_data), 64'd4);
    elem_data = gen(0, 3);
    @(negedge clk);
    elem_valid = 1'b0;
    chk(done && idx_data == 24'd6, "R10 original length", 64'(idx_data), 64'd6);
    chk(mask == 64'h7000_0000_0000_0000, "R5 short mask", mask, 64'h7000_0000_0000_0000);
    chk(idx_count == 7'd3, "R7 short count", 64'(idx_count), 64'd3);

    // R1: reset in the middle of a run
    @(negedge clk);
    start = 1'b1; vlen = 7'd10; cond = 2'd1; stride = 24'd1;
    @(negedge clk);
    start = 1'b0; elem_valid = 1'b1; elem_data = 64'd5;
    @(negedge clk);
    rst = 1'b1; elem_valid = 1'b0;
    @(negedge clk);
    chk(!busy && mask == 0 && idx_count == 0 && !idx_valid, "R1 mid-run reset", mask, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule